// File: doc/BRIEF.md
# Machine-Cycle Quarter Phase Generator with Stretch

This block splits a processor machine cycle into quarter phases. Each quarter lasts one period of the fast input clock. A normal machine cycle has four quarters. When stretch mode is on and the access type of the cycle is marked as critical, the final quarter is held for one more quarter. Slow external memory then gets a longer last quarter to meet its timing. Other cycles keep their normal length, so code that makes no critical access runs at full speed.

The access-type code, the stretch enable and the critical-type mask are read once per cycle, during the first quarter. That decision holds until the cycle ends. While the final quarter is held, the phase outputs do not change. A stretch-active flag marks the held quarters. A boundary strobe marks the last quarter of every cycle, so neighbouring logic knows when the next cycle begins. All pins are plain control and status signals. No data moves through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `qp_quarter_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is the first quarter with no stretch: `phase_oh` = 4'b0001 and `stretch_act` = 0. The `cyc_end` output is 0 in that quarter.
- R2: `phase_oh` is always one-hot. Bit 0 means Q1 and bit 3 means Q4. An unstretched cycle shows bits 0, 1, 2 and 3 in that order, one clock each.
- R3: While the enable sampled in Q1 is 0, the cycle is four quarters long, whatever the type code and mask are.
- R4: When the enable sampled in Q1 is 1 and mask bit `crit_mask[acc_type]` (sampled in Q1) is 1, the cycle is five quarters long. `phase_oh` stays at bit 3 for two consecutive clocks (Q4a, then Q4b).
- R5: When the enable is 1 but the selected mask bit is 0, the cycle is four quarters long.
- R6: `stretch_act` is 1 exactly during Q4a and Q4b of a stretched cycle, and 0 in every other quarter.
- R7: `cyc_end` is 1 for exactly one clock per cycle: during Q4 of a normal cycle, or during Q4b of a stretched cycle.
- R8: Changes to `acc_type`, `stretch_en` or `crit_mask` during Q2, Q3 or Q4 have no effect on the length of the current cycle.
- R9: The quarter after the last quarter of any cycle, stretched or not, is Q1 of the next cycle. No idle quarter comes between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one period is one quarter phase |
| rst | input | 1 | Synchronous reset, active high |
| stretch_en | input | 1 | Stretch mode enable, sampled in Q1 |
| acc_type | input | 3 | Memory access-type code of the cycle, sampled in Q1 |
| crit_mask | input | 8 | One bit per access type; 1 marks that type as critical |
| phase_oh | output | 4 | One-hot current quarter (bit 0 = Q1 ... bit 3 = Q4) |
| stretch_act | output | 1 | High during the two held quarters of a stretched cycle |
| cyc_end | output | 1 | High in the final quarter of each cycle |

## Verification
The bench builds the block with its default parameters. These are a 3-bit type code, four quarters per cycle and one held extra quarter. With these sizes, every one of the 256 mask patterns can be crossed with all eight type codes while stretch mode is on, in a few thousand clocks. A pseudo-random phase then changes every input on every clock, so the effect of mid-cycle changes is checked in every quarter. Another phase alternates stretched and normal cycles back to back. A behavioural model counts the quarters of each cycle and checks all three outputs on every clock.

// File: rtl/qp_pkg.sv
package qp_pkg;

  // Per-quarter status produced by the output stage.
  typedef struct packed {
    logic held;      // inside the stretched final quarter
    logic boundary;  // final quarter of the machine cycle
  } qp_flag_t;

  // Decides whether a cycle is to be stretched.
  function automatic logic qp_is_critical(input logic en, input logic sel_bit);
    return en & sel_bit;
  endfunction

endpackage

// File: rtl/qp_crit_decode.sv
module qp_crit_decode #(
  parameter int TYPE_W = 3
) (
  input  logic                     stretch_en,
  input  logic [TYPE_W-1:0]        acc_type,
  input  logic [(1<<TYPE_W)-1:0]   crit_mask,
  output logic                     crit
);
  import qp_pkg::*;

  localparam int NTYPES = 1 << TYPE_W;

  logic [NTYPES-1:0] type_sel;

  // One-hot decode of the access type, one comparator per type.
  genvar t;
  generate
    for (t = 0; t < NTYPES; t++) begin : g_sel
      assign type_sel[t] = (acc_type == TYPE_W'(t));
    end
  endgenerate

  always_comb begin
    crit = qp_is_critical(stretch_en, |(type_sel & crit_mask));
  end

endmodule

// File: rtl/qp_seq.sv
module qp_seq #(
  parameter int NUM_Q  = 4,
  parameter int HOLD_Q = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     crit_in,
  output logic [$clog2(NUM_Q)-1:0] ph_idx,
  output logic                     crit_q,
  output logic                     hold_done
);
  localparam int IDX_W = $clog2(NUM_Q);
  localparam int HC_W  = (HOLD_Q < 1) ? 1 : $clog2(HOLD_Q + 1);
  localparam logic [IDX_W-1:0] FIRST = '0;
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_Q - 1);
  localparam logic [HC_W-1:0]  HLIM  = HC_W'(HOLD_Q);

  logic [IDX_W-1:0] ph_d;
  logic [HC_W-1:0]  hold_cnt, hold_d;
  logic             crit_d;

  assign hold_done = (hold_cnt == HLIM);

  always_comb begin
    ph_d   = ph_idx;
    hold_d = hold_cnt;
    crit_d = crit_q;
    if (ph_idx == FIRST) begin
      crit_d = crit_in;            // decision taken once, in Q1
      ph_d   = ph_idx + 1'b1;
    end else if (ph_idx == LAST) begin
      if (crit_q && !hold_done) begin
        hold_d = hold_cnt + 1'b1;  // repeat the final quarter
      end else begin
        ph_d   = FIRST;
        hold_d = '0;
        crit_d = 1'b0;
      end
    end else begin
      ph_d = ph_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_idx   <= FIRST;
      hold_cnt <= '0;
      crit_q   <= 1'b0;
    end else begin
      ph_idx   <= ph_d;
      hold_cnt <= hold_d;
      crit_q   <= crit_d;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ph_idx == FIRST && !crit_q));

  // R4
  hold_last_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_idx == LAST && crit_q && !hold_done) |=> (ph_idx == LAST));

  // R5
  normal_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_idx == LAST && !crit_q) |=> (ph_idx == FIRST));

  // R8
  decision_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_idx != FIRST && ph_idx != LAST) |=> $stable(crit_q));

endmodule

// File: rtl/qp_outs.sv
module qp_outs #(
  parameter int NUM_Q = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NUM_Q)-1:0] ph_idx,
  input  logic                     crit_q,
  input  logic                     hold_done,
  output logic [NUM_Q-1:0]         phase_oh,
  output qp_pkg::qp_flag_t         flags
);
  import qp_pkg::*;

  localparam int IDX_W = $clog2(NUM_Q);

  genvar g;
  generate
    for (g = 0; g < NUM_Q; g++) begin : g_oh
      assign phase_oh[g] = (ph_idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    flags.held     = phase_oh[NUM_Q-1] & crit_q;
    flags.boundary = phase_oh[NUM_Q-1] & (~crit_q | hold_done);
  end

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1);

  // R6
  held_in_last_chk: assert property (@(posedge clk) disable iff (rst)
    flags.held |-> phase_oh[NUM_Q-1]);

  // R9
  next_is_first_chk: assert property (@(posedge clk) disable iff (rst)
    flags.boundary |=> phase_oh[0]);

  // R7
  single_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    flags.boundary |=> !flags.boundary);

endmodule

// File: rtl/qp_quarter_gen.sv
module qp_quarter_gen #(
  parameter int TYPE_W = 3,
  parameter int NUM_Q  = 4,
  parameter int HOLD_Q = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stretch_en,
  input  logic [TYPE_W-1:0]      acc_type,
  input  logic [(1<<TYPE_W)-1:0] crit_mask,
  output logic [NUM_Q-1:0]       phase_oh,
  output logic                   stretch_act,
  output logic                   cyc_end
);
  import qp_pkg::*;

  localparam int IDX_W = $clog2(NUM_Q);

  logic             crit;
  logic [IDX_W-1:0] ph_idx;
  logic             crit_q;
  logic             hold_done;
  qp_flag_t         flags;

  qp_crit_decode #(.TYPE_W(TYPE_W)) u_dec (
    .stretch_en (stretch_en),
    .acc_type   (acc_type),
    .crit_mask  (crit_mask),
    .crit       (crit)
  );

  qp_seq #(.NUM_Q(NUM_Q), .HOLD_Q(HOLD_Q)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .crit_in   (crit),
    .ph_idx    (ph_idx),
    .crit_q    (crit_q),
    .hold_done (hold_done)
  );

  qp_outs #(.NUM_Q(NUM_Q)) u_outs (
    .clk       (clk),
    .rst       (rst),
    .ph_idx    (ph_idx),
    .crit_q    (crit_q),
    .hold_done (hold_done),
    .phase_oh  (phase_oh),
    .flags     (flags)
  );

  assign stretch_act = flags.held;
  assign cyc_end     = flags.boundary;

  // R3
  no_stretch_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_oh[0] && !stretch_en) |=> ##[0:0] 1'b1 ##0 !crit_q);

endmodule

// File: tb/qp_quarter_gen_tb_top.sv
module qp_quarter_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stretch_en = 1'b0;
  logic [2:0] acc_type = 3'd0;
  logic [7:0] crit_mask = 8'd0;
  logic [3:0] phase_oh;
  logic       stretch_act;
  logic       cyc_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string seg = "R1";

  // model state
  int pos = 0;
  int len = 4;

  always #2 clk = ~clk;

  qp_quarter_gen dut_i (
    .clk(clk), .rst(rst), .stretch_en(stretch_en), .acc_type(acc_type),
    .crit_mask(crit_mask), .phase_oh(phase_oh), .stretch_act(stretch_act),
    .cyc_end(cyc_end)
  );

  // Behavioural reference: quarters elapsed in the cycle and its length.
  always @(posedge clk) begin
    if (rst) begin
      pos = 0;
      len = 4;
    end else if (pos == 0) begin
      len = (stretch_en && crit_mask[acc_type]) ? 5 : 4;
      pos = 1;
    end else if (pos == len - 1) begin
      pos = 0;
    end else begin
      pos = pos + 1;
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    logic [3:0] e_ph;
    logic e_st, e_end;
    if (!done) begin
      e_ph  = 4'b0001 << ((pos < 4) ? pos : 3);
      e_st  = (len == 5) && (pos >= 3);
      e_end = (pos == len - 1);
      checks++;
      if (phase_oh !== e_ph) begin
        errors++;
        $display("FAIL %s/R2 phase_oh actual %b expected %b", seg, phase_oh, e_ph);
      end
      checks++;
      if (stretch_act !== e_st) begin
        errors++;
        $display("FAIL R6 stretch_act actual %b expected %b (%s)", stretch_act, e_st, seg);
      end
      checks++;
      if (cyc_end !== e_end) begin
        errors++;
        $display("FAIL R7 cyc_end actual %b expected %b (%s)", cyc_end, e_end, seg);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // R1: reset state
    seg = "R1";
    step(3);
    rst = 1'b0;
    // R2/R3: stretch off, all types critical, still four quarters
    seg = "R3";
    crit_mask = 8'hFF;
    for (int t = 0; t < 8; t++) begin
      acc_type = 3'(t);
      step(4);
    end
    // R4/R5: enable on, sweep every mask against every type
    seg = "R4R5";
    stretch_en = 1'b1;
    for (int m = 0; m < 256; m++) begin
      for (int t = 0; t < 8; t++) begin
        crit_mask = 8'(m);
        acc_type  = 3'(t);
        wait (phase_oh[0] === 1'b1);
        step(1);
        while (phase_oh[0] !== 1'b1) step(1);
      end
    end
    // R9: alternate stretched and normal cycles
    seg = "R9";
    crit_mask = 8'b0000_0101;
    for (int k = 0; k < 40; k++) begin
      acc_type = (k % 2 == 0) ? 3'd2 : 3'd1;
      step(1);
      while (phase_oh[0] !== 1'b1) step(1);
    end
    // R8: inputs change on every quarter
    seg = "R8";
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stretch_en = lfsr[0] | lfsr[5];
      acc_type   = lfsr[3:1];
      crit_mask  = lfsr[15:8];
      step(1);
    end
    // R1: reset in the middle of a stretched cycle
    seg = "R1";
    stretch_en = 1'b1;
    crit_mask  = 8'hFF;
    while (phase_oh[3] !== 1'b1) step(1);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(12);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule